// File: doc/BRIEF.md
# BCD Alarm Comparator With Repeat

This block keeps four alarm bytes: seconds, minutes, hours and day of month. The low bits of each byte hold a BCD value, and bit 7 holds a repeat-mask flag. A separate counter supplies the current BCD time of day, together with a one-cycle strobe once per second. On every strobe the block compares the unmasked alarm fields against the time. When they agree, it emits an interrupt pulse one clock wide.

The four mask flags together choose the repeat period. With all flags clear the alarm is monthly. The flag sets date, date+hour and date+hour+minute give daily, hourly and per-minute alarms. Any other pattern fires on every strobe.

Software reaches the alarm bytes through a byte-wide register port. A write is refused when its BCD payload is out of range for its field. The refused write leaves the stored byte as it was.

Top module: `bcd_alarm`

## Requirements
- R1: Index 0 is alarm seconds, 1 is minutes, 2 is hours and 3 is date. After reset they hold 0x00, 0x00, 0x00 and 0x01. `rdata` shows the byte at `addr` one clock after `addr` is presented.
- R2: A write to seconds or minutes is stored only if bits 6:0 form BCD 00..59, with each nibble 9 or less. Otherwise the old byte stays.
- R3: A write to hours is stored only if bits 5:0 form BCD 00..23. Otherwise the old byte stays.
- R4: A write to date is stored only if bits 5:0 form a valid non-zero BCD value (01..39). Otherwise the old byte stays.
- R5: An accepted write stores the whole byte, including bit 7 and any unused bits, and reads back unchanged.
- R6: With the bit 7 flags {date,hour,minute,second} = 0000 (monthly), a strobe matches only if date (bits 5:0), hour (bits 5:0), minute and second (bits 6:0) all equal the time inputs.
- R7: Flags 1000 (daily): hour, minute and second must match, and the date is ignored.
- R8: Flags 1100 (hourly): minute and second must match.
- R9: Flags 1110 (per minute): only the second must match.
- R10: Every other flag pattern makes every strobe a match.
- R11: `irq` is high for exactly the one clock after a strobe cycle that matched. It is low in every other cycle, and never high without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the alarm byte at `addr` |
| addr | input | 2 | Alarm byte index for write and read |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| tick | input | 1 | One-cycle once-per-second strobe |
| tod_sec | input | 8 | Current seconds, BCD |
| tod_min | input | 8 | Current minutes, BCD |
| tod_hour | input | 8 | Current hours, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | One-cycle alarm pulse |

## Verification
The pulse-width property assumes that `tick` is never high in two consecutive cycles. This holds for a real once-per-second strobe. Without it, the every-strobe mode would hold `irq` high across adjacent cycles. The bench raises `tick` for one cycle and then keeps it low for at least two, so the assumption always holds. The time inputs are changed only together with a strobe, or while it is low, so a comparison never sees a half-updated time.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int BCD_W      = 8;
  localparam int NUM_FIELDS = 4;
  localparam int ADDR_W     = $clog2(NUM_FIELDS);

  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DATE = 3;

  typedef enum logic [2:0] {
    RPT_MONTH  = 3'd0,
    RPT_DAY    = 3'd1,
    RPT_HOUR   = 3'd2,
    RPT_MINUTE = 3'd3,
    RPT_SECOND = 3'd4
  } rpt_mode_e;

  // Bits of a field that carry its BCD payload
  function automatic logic [BCD_W-1:0] field_mask(input int idx);
    if (idx == FLD_SEC || idx == FLD_MIN) return 8'h7F;
    return 8'h3F;
  endfunction

  function automatic logic [BCD_W-1:0] field_reset(input int idx);
    if (idx == FLD_DATE) return 8'h01;
    return 8'h00;
  endfunction

  // Range check of the payload of one field
  function automatic logic bcd_field_ok(input int idx, input logic [BCD_W-1:0] b);
    logic [BCD_W-1:0] v;
    int dec;
    v = b & field_mask(idx);
    if (v[3:0] > 4'd9 || v[7:4] > 4'd9) return 1'b0;
    dec = int'(v[7:4]) * 10 + int'(v[3:0]);
    if (idx == FLD_SEC || idx == FLD_MIN) return dec <= 59;
    if (idx == FLD_HOUR) return dec <= 23;
    return dec != 0;
  endfunction

  // Number of fields, counted from seconds upward, that take part in a match
  function automatic logic [2:0] compare_count(input rpt_mode_e m);
    case (m)
      RPT_MONTH:  return 3'd4;
      RPT_DAY:    return 3'd3;
      RPT_HOUR:   return 3'd2;
      RPT_MINUTE: return 3'd1;
      default:    return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import bcd_alarm_pkg::*;
#(
  parameter int DW = BCD_W,
  parameter int NF = NUM_FIELDS,
  parameter int AW = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [NF-1:0][DW-1:0] regs_q,
  output logic [DW-1:0]        rdata
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic [DW-1:0] q;
    logic          accept;
    assign accept = wr_en && (addr == AW'(i)) && bcd_field_ok(i, wdata);
    always_ff @(posedge clk) begin
      if (rst)         q <= field_reset(i);
      else if (accept) q <= wdata;
    end
    assign regs_q[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= regs_q[addr];
  end
endmodule

// File: rtl/alarm_repeat_decode.sv
module alarm_repeat_decode
  import bcd_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS
) (
  input  logic [NF-1:0] mask_bits,   // [0]=sec .. [3]=date
  output rpt_mode_e     mode
);
  always_comb begin
    case (mask_bits)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import bcd_alarm_pkg::*;
#(
  parameter int DW = BCD_W,
  parameter int NF = NUM_FIELDS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  rpt_mode_e             mode,
  input  logic [NF-1:0][DW-1:0] alarm,
  input  logic [NF-1:0][DW-1:0] tod,
  output logic                  irq
);
  logic [NF-1:0] eq;
  logic [NF-1:0] need;
  logic [2:0]    n_cmp;
  logic          hit;

  assign n_cmp = compare_count(mode);

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign eq[i]   = ((alarm[i] ^ tod[i]) & field_mask(i)) == '0;
    assign need[i] = 3'(i) < n_cmp;
  end

  assign hit = &(eq | ~need);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= tick && hit;
  end
endmodule

// File: rtl/bcd_alarm.sv
module bcd_alarm
  import bcd_alarm_pkg::*;
#(
  parameter int DW = BCD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tick,
  input  logic [DW-1:0] tod_sec,
  input  logic [DW-1:0] tod_min,
  input  logic [DW-1:0] tod_hour,
  input  logic [DW-1:0] tod_date,
  output logic          irq
);
  localparam int NF = NUM_FIELDS;

  logic [NF-1:0][DW-1:0] alarm_q;
  logic [NF-1:0][DW-1:0] tod_v;
  logic [NF-1:0]         mask_bits;
  rpt_mode_e             mode;

  assign tod_v[FLD_SEC]  = tod_sec;
  assign tod_v[FLD_MIN]  = tod_min;
  assign tod_v[FLD_HOUR] = tod_hour;
  assign tod_v[FLD_DATE] = tod_date;

  for (genvar i = 0; i < NF; i++) begin : g_mask
    assign mask_bits[i] = alarm_q[i][DW-1];
  end

  alarm_regfile #(.DW(DW), .NF(NF), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .regs_q(alarm_q), .rdata(rdata)
  );

  alarm_repeat_decode #(.NF(NF)) u_dec (
    .mask_bits(mask_bits), .mode(mode)
  );

  alarm_match #(.DW(DW), .NF(NF)) u_match (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode),
    .alarm(alarm_q), .tod(tod_v), .irq(irq)
  );
endmodule

// File: rtl/bcd_alarm_checker.sv
module bcd_alarm_checker
  import bcd_alarm_pkg::*;
#(
  parameter int DW = BCD_W,
  parameter int AW = ADDR_W
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [AW-1:0]                 addr,
  input logic [DW-1:0]                 wdata,
  input logic                          tick,
  input logic                          irq,
  input logic [NUM_FIELDS-1:0][DW-1:0] alarm_q
);
  a_r2_bad_nibble_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(FLD_SEC) && wdata[3:0] > 4'd9) |=> $stable(alarm_q[FLD_SEC]));

  a_r3_hour_tens_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(FLD_HOUR) && wdata[5:4] == 2'b11) |=> $stable(alarm_q[FLD_HOUR]));

  a_r4_zero_date_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(FLD_DATE) && wdata[5:0] == 6'd0) |=> $stable(alarm_q[FLD_DATE]));

  a_r10_all_masks_fire: assert property (@(posedge clk) disable iff (rst)
    (tick && alarm_q[0][DW-1] && alarm_q[1][DW-1] && alarm_q[2][DW-1] && alarm_q[3][DW-1])
    |=> irq);

  a_r11_irq_needs_tick: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick));

  a_r11_single_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind bcd_alarm bcd_alarm_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tick(tick), .irq(irq), .alarm_q(alarm_q)
);

// File: tb/bcd_alarm_test.sv
module bcd_alarm_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic [7:0] tod_sec = 8'h00, tod_min = 8'h00, tod_hour = 8'h00, tod_date = 8'h01;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  bcd_alarm uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tick(tick), .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
    .tod_date(tod_date), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mreg [4];
  logic       exp_irq;
  logic [7:0] exp_rd;
  logic       live = 1'b0;

  function automatic bit m_ok(input int f, input logic [7:0] b);
    int v, t, u;
    v = (f < 2) ? int'(b) % 128 : int'(b) % 64;
    t = v / 16;
    u = v % 16;
    if (t > 9 || u > 9) return 0;
    v = t * 10 + u;
    if (f < 2)  return v <= 59;
    if (f == 2) return v <= 23;
    return v != 0;
  endfunction

  function automatic bit m_hit();
    bit ms, mm, mh, md, es, em, eh, ed;
    ms = mreg[0][7]; mm = mreg[1][7]; mh = mreg[2][7]; md = mreg[3][7];
    es = (int'(mreg[0]) % 128) == (int'(tod_sec)  % 128);
    em = (int'(mreg[1]) % 128) == (int'(tod_min)  % 128);
    eh = (int'(mreg[2]) % 64)  == (int'(tod_hour) % 64);
    ed = (int'(mreg[3]) % 64)  == (int'(tod_date) % 64);
    if (!md && !mh && !mm && !ms) return ed && eh && em && es;
    if ( md && !mh && !mm && !ms) return eh && em && es;
    if ( md &&  mh && !mm && !ms) return em && es;
    if ( md &&  mh &&  mm && !ms) return es;
    return 1;
  endfunction

  always @(posedge clk) begin
    live <= !rst;
    if (rst) begin
      mreg[0] <= 8'h00; mreg[1] <= 8'h00; mreg[2] <= 8'h00; mreg[3] <= 8'h01;
      exp_irq <= 1'b0;
      exp_rd  <= 8'h00;
    end else begin
      exp_rd  <= mreg[addr];
      exp_irq <= tick && m_hit();
      if (wr_en && m_ok(int'(addr), wdata)) mreg[addr] <= wdata;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R11 irq vs model", {7'd0, irq}, {7'd0, exp_irq});
      chk("R1 rdata vs model", rdata, exp_rd);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic tick_chk(input string tag, input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] d, input logic exp);
    @(negedge clk);
    tick = 1'b1; tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
    @(negedge clk);
    tick = 1'b0;
    chk(tag, {7'd0, irq}, {7'd0, exp});
    @(negedge clk);
    chk("R11 pulse drops", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset contents
    rd_chk("R1 reset sec",  2'd0, 8'h00);
    rd_chk("R1 reset min",  2'd1, 8'h00);
    rd_chk("R1 reset hour", 2'd2, 8'h00);
    rd_chk("R1 reset date", 2'd3, 8'h01);

    // R2 seconds / minutes
    wr(2'd0, 8'h45); rd_chk("R2 sec 45 kept", 2'd0, 8'h45);
    wr(2'd0, 8'h5A); rd_chk("R2 sec bad nibble", 2'd0, 8'h45);
    wr(2'd0, 8'h60); rd_chk("R2 sec 60 refused", 2'd0, 8'h45);
    wr(2'd1, 8'h59); rd_chk("R2 min 59 kept", 2'd1, 8'h59);
    wr(2'd1, 8'h7F); rd_chk("R2 min 7F refused", 2'd1, 8'h59);
    // R5 whole byte stored
    wr(2'd1, 8'hD9); rd_chk("R5 min with flags", 2'd1, 8'hD9);

    // R3 hours
    wr(2'd2, 8'h24); rd_chk("R3 hour 24 refused", 2'd2, 8'h00);
    wr(2'd2, 8'h23); rd_chk("R3 hour 23 kept", 2'd2, 8'h23);
    wr(2'd2, 8'h63); rd_chk("R5 hour bit6 kept", 2'd2, 8'h63);
    wr(2'd2, 8'h1C); rd_chk("R3 hour bad nibble", 2'd2, 8'h63);

    // R4 date
    wr(2'd3, 8'h00); rd_chk("R4 date 0 refused", 2'd3, 8'h01);
    wr(2'd3, 8'h1A); rd_chk("R4 date bad nibble", 2'd3, 8'h01);
    wr(2'd3, 8'h15); rd_chk("R4 date 15 kept", 2'd3, 8'h15);

    // R6 monthly
    wr(2'd0, 8'h30); wr(2'd1, 8'h20); wr(2'd2, 8'h10); wr(2'd3, 8'h15);
    tick_chk("R6 monthly match", 8'h30, 8'h20, 8'h10, 8'h15, 1'b1);
    tick_chk("R6 monthly date differs", 8'h30, 8'h20, 8'h10, 8'h16, 1'b0);
    tick_chk("R6 monthly sec differs", 8'h31, 8'h20, 8'h10, 8'h15, 1'b0);

    // R7 daily
    wr(2'd3, 8'h95);
    tick_chk("R7 daily any date", 8'h30, 8'h20, 8'h10, 8'h03, 1'b1);
    tick_chk("R7 daily hour differs", 8'h30, 8'h20, 8'h11, 8'h03, 1'b0);

    // R8 hourly
    wr(2'd2, 8'h90);
    tick_chk("R8 hourly any hour", 8'h30, 8'h20, 8'h05, 8'h03, 1'b1);
    tick_chk("R8 hourly min differs", 8'h30, 8'h21, 8'h05, 8'h03, 1'b0);

    // R9 per minute
    wr(2'd1, 8'hA0);
    tick_chk("R9 minute any min", 8'h30, 8'h44, 8'h05, 8'h03, 1'b1);
    tick_chk("R9 minute sec differs", 8'h31, 8'h44, 8'h05, 8'h03, 1'b0);

    // R10 every second
    wr(2'd0, 8'hB0);
    tick_chk("R10 all flags", 8'h31, 8'h44, 8'h05, 8'h03, 1'b1);
    wr(2'd0, 8'h80); wr(2'd1, 8'h20); wr(2'd2, 8'h10); wr(2'd3, 8'h15);
    tick_chk("R10 sec flag only", 8'h00, 8'h00, 8'h00, 8'h01, 1'b1);
    wr(2'd0, 8'h30); wr(2'd2, 8'h90);
    tick_chk("R10 hour flag only", 8'h00, 8'h00, 8'h00, 8'h01, 1'b1);

    // R11 no strobe, no pulse, even while every-second mode is selected
    @(negedge clk); tod_sec = 8'h30; tod_min = 8'h20; tod_hour = 8'h10; tod_date = 8'h15;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 quiet without tick", {7'd0, irq}, 8'h00);
    end

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule